// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block decodes one instruction of a small 32-bit register-machine instruction set. It takes a six-byte window that starts at the current program counter, together with the program counter itself. The first byte alone fixes the instruction class and its length of 1, 2, 5 or 6 bytes. The block then extracts the opcode and function nibbles, the two register specifiers and a little-endian 32-bit constant. It also produces the sequential next address and a status code.

The status code flags opcodes and function codes outside the defined set. It also flags instructions whose last byte would lie past the end of instruction memory, whose size is a parameter. All decoded fields are registered once, so each result appears one clock after its window was presented. A fetch buffer, or a testbench, supplies the window. Register reads and execution take place downstream.

Top module: `instr_decoder`

## Requirements
- R1: While rst_ni is low, every output is zero, including stat_o (0 means no result yet).
- R2: len_o depends only on the opcode nibble: 1 for opcodes 0x0, 0x1, 0x9 and 0xC-0xF; 2 for 0x2, 0x6, 0xA, 0xB; 5 for 0x7, 0x8; 6 for 0x3, 0x4, 0x5.
- R3: icode_o is bits 7:4 of window byte 0, and ifun_o is bits 3:0 of window byte 0. Window byte k sits at bits 8k+7:8k of win_i.
- R4: For opcodes 0x2-0x6 and 0xA-0xB, ra_o is the high nibble and rb_o is the low nibble of byte 1. For all other opcodes both are 0xF.
- R5: valc_o is little-endian. It is made of bytes 2..5 (byte 2 least significant) for opcodes 0x3-0x5, and of bytes 1..4 for opcodes 0x7-0x8. For all other opcodes it is zero.
- R6: next_pc_o equals pc_i plus len_o, modulo 2^32.
- R7: stat_o is 4 (invalid) in three cases: the opcode is 0xC-0xF; the opcode is 0x6 with a function code above 3; or the opcode is 0x2 or 0x7 with a function code above 6. Every other opcode with a nonzero function code is also invalid.
- R8: A byte of 0x00 gives stat_o = 2 (halt). Any other valid instruction within bounds gives stat_o = 1 (ok).
- R9: When pc_i + len_o, computed without wraparound, exceeds MEM_BYTES, stat_o is 3 (bad address). This status takes priority over invalid and halt.
- R10: Each output reflects the pc_i and win_i values sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of window byte 0 |
| win_i | input | 48 | Six instruction bytes, byte 0 in the low bits |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier, 0xF when absent |
| rb_o | output | 4 | Second register specifier, 0xF when absent |
| valc_o | output | 32 | Little-endian constant, zero when absent |
| next_pc_o | output | 32 | Sequential next address |
| len_o | output | 3 | Instruction length in bytes |
| stat_o | output | 3 | 1 ok, 2 halt, 3 bad address, 4 invalid, 0 in reset |

## Verification
The assertions assume that win_i and pc_i are stable and free of X or Z at each rising edge while reset is released. They also assume that MEM_BYTES is no larger than 2^32. The stimulus changes inputs only one time unit after a rising edge and always drives fully known values. It sweeps every opcode and function pair at a low address and places instructions at the memory boundary and at the top of the 32-bit address space. Random windows fill the remaining runs, with their addresses kept in range so that in-bounds decoding is also covered.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WIN_BYTES = 6;
  localparam int unsigned LEN_W = 3;
  localparam int unsigned STAT_W = 3;

  localparam logic [STAT_W-1:0] ST_NONE = 3'd0;
  localparam logic [STAT_W-1:0] ST_AOK  = 3'd1;
  localparam logic [STAT_W-1:0] ST_HLT  = 3'd2;
  localparam logic [STAT_W-1:0] ST_ADR  = 3'd3;
  localparam logic [STAT_W-1:0] ST_INS  = 3'd4;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_NOP  = 4'h1, OP_MOVE = 4'h2, OP_IMM  = 4'h3,
    OP_STR  = 4'h4, OP_LDR  = 4'h5, OP_ALU  = 4'h6, OP_JUMP = 4'h7,
    OP_CALL = 4'h8, OP_RET  = 4'h9, OP_PUSH = 4'hA, OP_POP  = 4'hB
  } opcode_e;

  localparam logic [3:0] REG_NONE = 4'hF;
  localparam logic [3:0] FN_MAX_ALU = 4'd3;
  localparam logic [3:0] FN_MAX_CC  = 4'd6;
endpackage

// File: rtl/idec_class.sv
module idec_class
  import idec_pkg::*;
(
  input  logic [7:0]       op_byte_i,
  output logic [LEN_W-1:0] len_o,
  output logic             has_reg_o,
  output logic             has_const_o,
  output logic             const_at2_o,
  output logic             ins_o,
  output logic             halt_o
);
  logic [3:0] icode, ifun;
  assign icode = op_byte_i[7:4];
  assign ifun  = op_byte_i[3:0];

  always_comb begin
    len_o       = 3'd1;
    has_reg_o   = 1'b0;
    has_const_o = 1'b0;
    const_at2_o = 1'b0;
    ins_o       = (ifun != 4'd0);
    halt_o      = 1'b0;
    case (icode)
      OP_HALT: halt_o = (ifun == 4'd0);
      OP_NOP, OP_RET: ;
      OP_MOVE: begin
        len_o     = 3'd2;
        has_reg_o = 1'b1;
        ins_o     = (ifun > FN_MAX_CC);
      end
      OP_ALU: begin
        len_o     = 3'd2;
        has_reg_o = 1'b1;
        ins_o     = (ifun > FN_MAX_ALU);
      end
      OP_PUSH, OP_POP: begin
        len_o     = 3'd2;
        has_reg_o = 1'b1;
      end
      OP_IMM, OP_STR, OP_LDR: begin
        len_o       = 3'd6;
        has_reg_o   = 1'b1;
        has_const_o = 1'b1;
        const_at2_o = 1'b1;
      end
      OP_JUMP: begin
        len_o       = 3'd5;
        has_const_o = 1'b1;
        ins_o       = (ifun > FN_MAX_CC);
      end
      OP_CALL: begin
        len_o       = 3'd5;
        has_const_o = 1'b1;
      end
      default: ins_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int unsigned CONST_BYTES = WORD_W / 8,
  localparam int unsigned TAIL_BYTES = CONST_BYTES + 1
) (
  input  logic [TAIL_BYTES*8-1:0]  tail_i,
  input  logic                     has_reg_i,
  input  logic                     has_const_i,
  input  logic                     const_at2_i,
  output logic [3:0]               ra_o,
  output logic [3:0]               rb_o,
  output logic [CONST_BYTES*8-1:0] valc_o
);
  assign ra_o = has_reg_i ? tail_i[7:4] : REG_NONE;
  assign rb_o = has_reg_i ? tail_i[3:0] : REG_NONE;

  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_lane
    logic [7:0] lo_b, hi_b;
    assign lo_b = tail_i[k*8 +: 8];
    assign hi_b = tail_i[(k+1)*8 +: 8];
    assign valc_o[k*8 +: 8] = !has_const_i ? 8'h00 : (const_at2_i ? hi_b : lo_b);
  end
endmodule

// File: rtl/idec_bound.sv
module idec_bound
  import idec_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 4096
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [WORD_W-1:0] next_pc_o,
  output logic              adr_o
);
  localparam logic [WORD_W:0] MEM_LIM = (WORD_W+1)'(MEM_BYTES);
  logic [WORD_W:0] end_addr;
  assign end_addr  = {1'b0, pc_i} + (WORD_W+1)'(len_i);
  assign next_pc_o = end_addr[WORD_W-1:0];
  assign adr_o     = (end_addr > MEM_LIM);
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] pc_i,
  input  logic [47:0] win_i,
  output logic [3:0]  icode_o,
  output logic [3:0]  ifun_o,
  output logic [3:0]  ra_o,
  output logic [3:0]  rb_o,
  output logic [31:0] valc_o,
  output logic [31:0] next_pc_o,
  output logic [2:0]  len_o,
  output logic [2:0]  stat_o
);
  logic [LEN_W-1:0]  len_c;
  logic              has_reg_c, has_const_c, const_at2_c, ins_c, halt_c, adr_c;
  logic [3:0]        ra_c, rb_c;
  logic [WORD_W-1:0] valc_c, next_pc_c;
  logic [STAT_W-1:0] stat_c;

  idec_class i_class (
    .op_byte_i  (win_i[7:0]),
    .len_o      (len_c),
    .has_reg_o  (has_reg_c),
    .has_const_o(has_const_c),
    .const_at2_o(const_at2_c),
    .ins_o      (ins_c),
    .halt_o     (halt_c)
  );

  idec_fields i_fields (
    .tail_i     (win_i[WIN_BYTES*8-1:8]),
    .has_reg_i  (has_reg_c),
    .has_const_i(has_const_c),
    .const_at2_i(const_at2_c),
    .ra_o       (ra_c),
    .rb_o       (rb_c),
    .valc_o     (valc_c)
  );

  idec_bound #(.MEM_BYTES(MEM_BYTES)) i_bound (
    .pc_i     (pc_i),
    .len_i    (len_c),
    .next_pc_o(next_pc_c),
    .adr_o    (adr_c)
  );

  // address fault outranks opcode fault, which outranks halt
  always_comb begin
    if (adr_c)       stat_c = ST_ADR;
    else if (ins_c)  stat_c = ST_INS;
    else if (halt_c) stat_c = ST_HLT;
    else             stat_c = ST_AOK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icode_o   <= '0;
      ifun_o    <= '0;
      ra_o      <= '0;
      rb_o      <= '0;
      valc_o    <= '0;
      next_pc_o <= '0;
      len_o     <= '0;
      stat_o    <= ST_NONE;
    end else begin
      icode_o   <= win_i[7:4];
      ifun_o    <= win_i[3:0];
      ra_o      <= ra_c;
      rb_o      <= rb_c;
      valc_o    <= valc_c;
      next_pc_o <= next_pc_c;
      len_o     <= len_c;
      stat_o    <= stat_c;
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != ST_NONE) |-> (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6)); // R2
  AST_NEXT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (next_pc_o == $past(pc_i) + 32'(len_o))); // R6
  AST_NO_REG_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != ST_NONE && (icode_o == 4'h0 || icode_o == 4'h1 || icode_o == 4'h7 ||
     icode_o == 4'h8 || icode_o == 4'h9)) |-> (ra_o == REG_NONE && rb_o == REG_NONE)); // R4
  AST_HALT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == ST_HLT) |-> (icode_o == 4'h0 && ifun_o == 4'h0 && len_o == 3'd1)); // R8
  AST_INS_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == ST_INS) |-> (icode_o > 4'hB || ifun_o != 4'h0)); // R7
  AST_CONST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o == 3'd1 || len_o == 3'd2) |-> (valc_o == 32'h0)); // R5
endmodule

// File: tb/test_instr_decoder.sv
module test_instr_decoder;
  localparam longint unsigned MEM = 4096;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pc;
  logic [47:0] win;
  logic [3:0] icode, ifun, ra, rb;
  logic [31:0] valc, npc;
  logic [2:0] len, stat;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  instr_decoder #(.MEM_BYTES(MEM)) i_instr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .win_i(win),
    .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
    .valc_o(valc), .next_pc_o(npc), .len_o(len), .stat_o(stat));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [47:0] w);
    int l, st;
    logic [3:0] oc, fc, e_ra, e_rb;
    logic [31:0] e_c;
    bit bad;
    longint unsigned endp;
    pc = p; win = w;
    @(posedge clk); #1;
    oc = w[7:4]; fc = w[3:0];
    e_ra = 4'hF; e_rb = 4'hF; e_c = 0;
    case (oc)
      4'h0, 4'h1, 4'h9: l = 1;
      4'h2, 4'h6, 4'hA, 4'hB: l = 2;
      4'h7, 4'h8: l = 5;
      4'h3, 4'h4, 4'h5: l = 6;
      default: l = 1;
    endcase
    if (l == 2 || l == 6) begin e_ra = w[15:12]; e_rb = w[11:8]; end
    if (l == 6) e_c = w[47:16];
    if (l == 5) e_c = w[39:8];
    if (oc > 4'hB) bad = 1;
    else if (oc == 4'h6) bad = fc > 3;
    else if (oc == 4'h2 || oc == 4'h7) bad = fc > 6;
    else bad = fc != 0;
    endp = longint'(p) + l;
    if (endp > MEM) st = 3;
    else if (bad) st = 4;
    else if (oc == 0) st = 2;
    else st = 1;
    chk("R3 icode", icode, oc);
    chk("R3 ifun", ifun, fc);
    chk("R2 len", len, l);
    chk("R4 ra", ra, e_ra);
    chk("R4 rb", rb, e_rb);
    chk("R5 valc", valc, e_c);
    chk("R6 next_pc", npc, 32'(endp));
    if (st == 3) chk("R9 stat", stat, st);
    else if (st == 4) chk("R7 stat", stat, st);
    else chk("R8 stat", stat, st);
  endtask

  initial begin
    #(5ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pc = 32'h10; win = 48'h0;
    #12;
    // R1: reset state
    chk("R1 stat", stat, 0); chk("R1 len", len, 0); chk("R1 valc", valc, 0);
    chk("R1 next_pc", npc, 0); chk("R1 ra", ra, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R10: one-cycle latency, every opcode/function pair
    for (int b = 0; b < 256; b++)
      apply(32'h40 + 32'(b), {40'h1122334455 ^ {32'h0, 8'(b)}, 8'(b)});
    // R5 byte order
    apply(32'h100, 48'h78563412_2A_30);
    apply(32'h104, 48'h00_EFBEADDE_70);
    // R9 boundary cases
    apply(32'(MEM - 6), 48'h04030201_F1_30);
    apply(32'(MEM - 5), 48'h04030201_F1_30);
    apply(32'(MEM - 1), 48'h10);
    apply(32'(MEM), 48'h10);
    apply(32'(MEM - 1), 48'h00);
    apply(32'(MEM), 48'h00);
    apply(32'(MEM - 1), 48'hF0);
    apply(32'(MEM), 48'hF0);
    apply(32'(MEM - 4), 48'h0000000000_79);
    apply(32'hFFFF_FFFF, 48'h10);
    apply(32'hFFFF_FFFC, 48'h0000000000_80);
    for (int n = 0; n < 400; n++)
      apply($urandom % 32'(MEM + 8), {$urandom, 16'($urandom)});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule